// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit timer/counter channels. Each channel keeps its count as a low byte and a high byte. Software reaches both bytes, a shared mode byte and a control byte through a simple register port. A machine-cycle `tick` strobe paces all counting. For each channel, the mode byte selects the count source, which is either internal machine cycles or falling edges on the channel's count pin. It also sets optional gating from the channel's gate pin and picks one of four counting arrangements.

When a channel's count rolls over, the block raises that channel's overflow flag. An interrupt controller clears the flag with a one-cycle acknowledge pulse once it has vectored to the handler. Software can also read and write the flags through the control byte. In the split arrangement, channel 0 is divided into two 8-bit counters and channel 1 is frozen. The second counter of channel 0 borrows the run bit and the overflow flag of channel 1.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset, every count byte, the mode byte, the control byte, both overflow flags and `reg_rdata` are zero.
- R2: Register addresses are: 0 = channel 0 low byte, 1 = channel 0 high byte, 2 = channel 1 low byte, 3 = channel 1 high byte, 4 = mode byte, 5 = control byte. Other addresses read zero.
  - The mode byte has one nibble per channel: bits 3:0 for channel 0 and bits 7:4 for channel 1. Within a nibble, bit 3 is gate enable, bit 2 is the source select (1 = count pin) and bits 1:0 are the mode.
  - In the control byte, bit 0 is run 0, bit 1 is run 1, bit 4 is flag 0 and bit 5 is flag 1.
  - A write lands at the clock edge. `reg_rdata` shows the addressed register one cycle after the address is presented.
- R3: A channel whose run bit is 0 does not count, whatever its ticks or pins do.
- R4: When gate enable is 1, the channel counts only while its gate pin is high and its run bit is 1.
- R5: With source select 1, the channel samples its count pin on each tick. It counts once on a tick where the pin is low and the sample taken at the previous tick was high. Pin changes between ticks are not seen.
- R6: Mode 01 counts the 16-bit value {high, low}. The step from FFFF to 0000 sets the channel's flag in the same clock edge.
- R7: Mode 00 uses low-byte bits 4:0 as a divide-by-32 prescaler. When they wrap from 31 to 0, the high byte increments, and low-byte bits 7:5 keep their value. The flag is set when the high byte wraps from FF to 00.
- R8: Mode 10 counts in the low byte. On the step past FF, the low byte reloads from the high byte and the flag is set. The high byte is unchanged.
- R9: In mode 11, channel 0's low byte counts under channel 0's source, gate and run bit, and sets flag 0.
  - Channel 0's high byte counts every tick while run 1 is set, and sets flag 1 when it wraps.
  - Channel 1 in mode 11 holds both of its bytes.
- R10: A pulse on `ovf_clr[i]` clears flag i. If an overflow sets flag i in the same cycle, the set wins.
- R11: A register write to a count byte takes precedence over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | Gate pins, one per channel |
| ovf_clr | input | 2 | Flag clear from interrupt acknowledge |
| ovf_flag | output | 2 | Overflow flags |

## Verification
Most internal faults show up at the count bytes. A wrong prescaler boundary, reload source or carry path gives a count byte that differs from the computed value on the first read after the offending tick. A wrong flag path shows on `ovf_flag` one clock after the rollover edge. The vectors therefore place counts right below each wrap point, so the error appears within one or two ticks. The split mode and the set-versus-clear race are exercised because their routing faults stay hidden in every other mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_PRE    = 2'b00,
    MD_WIDE   = 2'b01,
    MD_RELOAD = 2'b10,
    MD_SPLIT  = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate_en;
    logic      src_pin;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam int CFG_W = 4;
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic gate_en,
  input  logic src_pin,
  input  logic gate_pin,
  input  logic cnt_pin,
  output logic evt
);
  logic smp_q;
  logic allow;

  // pin sampled once per machine cycle
  always_ff @(posedge clk) begin
    if (rst)       smp_q <= 1'b0;
    else if (tick) smp_q <= cnt_pin;
  end

  always_comb begin
    allow = run & (~gate_en | gate_pin);
    evt   = tick & allow & (~src_pin | (smp_q & ~cnt_pin));
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W        = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  tmr_mode_e    mode,
  input  logic         evt,
  input  logic         hi_evt,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_main,
  output logic         ovf_split
);
  logic [W-1:0]   lo_n, hi_n;
  logic [2*W-1:0] wide;

  always_comb begin
    lo_n      = lo;
    hi_n      = hi;
    ovf_main  = 1'b0;
    ovf_split = 1'b0;
    wide      = {hi, lo} + 1'b1;
    case (mode)
      MD_PRE: if (evt) begin
        if (&lo[PRE_W-1:0]) begin
          lo_n[PRE_W-1:0] = '0;
          hi_n            = hi + 1'b1;
          ovf_main        = &hi;
        end else begin
          lo_n[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
        end
      end
      MD_WIDE: if (evt) begin
        {hi_n, lo_n} = wide;
        ovf_main     = &{hi, lo};
      end
      MD_RELOAD: if (evt) begin
        if (&lo) begin
          lo_n     = hi;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo + 1'b1;
        end
      end
      default: if (SPLIT_OK) begin
        if (evt) begin
          lo_n     = lo + 1'b1;
          ovf_main = &lo;
        end
        if (hi_evt) begin
          hi_n      = hi + 1'b1;
          ovf_split = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_RELOAD && evt && (&lo) && !wr_lo) |=> (lo == $past(hi)));

  assert_prescale_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_PRE && !(&lo[PRE_W-1:0]) && !wr_hi) |=> $stable(hi));

  generate
    if (!SPLIT_OK) begin : g_frozen
      assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_SPLIT && !wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 5,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [1:0]    cnt_pin,
  input  logic [1:0]    gate_pin,
  input  logic [1:0]    ovf_clr,
  output logic [1:0]    ovf_flag
);
  localparam int NCH = 2;
  localparam logic [AW-1:0] A_MODE = AW'(2 * NCH);
  localparam logic [AW-1:0] A_CTRL = AW'(2 * NCH + 1);
  localparam int RUN_LSB  = 0;
  localparam int FLAG_LSB = 4;

  logic [NCH*CFG_W-1:0] mode_q;
  logic [NCH-1:0]       run_q;
  logic [NCH-1:0]       flag_q;
  chan_cfg_t            cfg [NCH];
  logic [W-1:0]         lo [NCH];
  logic [W-1:0]         hi [NCH];
  logic [NCH-1:0]       evt, ovf_main, ovf_split, wr_lo, wr_hi, hi_evt;
  logic                 split0;
  logic [NCH-1:0]       flag_set;
  logic                 ctrl_wr;

  assign split0  = (cfg[0].mode == MD_SPLIT);
  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign cfg[c]   = chan_cfg_t'(mode_q[c*CFG_W +: CFG_W]);
      assign wr_lo[c] = reg_we && (reg_addr == AW'(2 * c));
      assign wr_hi[c] = reg_we && (reg_addr == AW'(2 * c + 1));
      if (c == 0) begin : g_hi_evt
        assign hi_evt[c] = tick & run_q[1] & split0;
      end else begin : g_no_hi_evt
        assign hi_evt[c] = 1'b0;
      end

      tmr_evt u_evt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (run_q[c]),
        .gate_en  (cfg[c].gate_en),
        .src_pin  (cfg[c].src_pin),
        .gate_pin (gate_pin[c]),
        .cnt_pin  (cnt_pin[c]),
        .evt      (evt[c])
      );

      tmr_core #(.W(W), .PRE_W(PRE_W), .SPLIT_OK(c == 0)) u_core (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg[c].mode),
        .evt       (evt[c]),
        .hi_evt    (hi_evt[c]),
        .wr_lo     (wr_lo[c]),
        .wr_hi     (wr_hi[c]),
        .wdata     (reg_wdata),
        .lo        (lo[c]),
        .hi        (hi[c]),
        .ovf_main  (ovf_main[c]),
        .ovf_split (ovf_split[c])
      );
    end
  endgenerate

  // flag 1 belongs to channel 0's upper half while channel 0 is split
  always_comb begin
    flag_set[0] = ovf_main[0];
    flag_set[1] = split0 ? ovf_split[0] : ovf_main[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) mode_q <= reg_wdata[NCH*CFG_W-1:0];
      if (ctrl_wr) run_q <= reg_wdata[RUN_LSB +: NCH];
      for (int i = 0; i < NCH; i++) begin
        if (ctrl_wr)          flag_q[i] <= reg_wdata[FLAG_LSB + i];
        if (ovf_clr[i])       flag_q[i] <= 1'b0;
        if (flag_set[i])      flag_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        AW'(0):  reg_rdata <= lo[0];
        AW'(1):  reg_rdata <= hi[0];
        AW'(2):  reg_rdata <= lo[1];
        AW'(3):  reg_rdata <= hi[1];
        A_MODE:  reg_rdata <= W'(mode_q);
        A_CTRL:  reg_rdata <= W'({flag_q, 2'b00, run_q});
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign ovf_flag = flag_q;

  assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q == '0 && !reg_we) |=> ($stable(lo[0]) && $stable(hi[0]) &&
                                  $stable(lo[1]) && $stable(hi[1])));

  assert_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg[0].gate_en && !gate_pin[0] && !reg_we && !split0) |=>
      ($stable(lo[0]) && $stable(hi[0])));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_main[0] |=> ovf_flag[0]);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr[0] && !flag_set[0] && !ctrl_wr) |=> !ovf_flag[0]);
endmodule

// File: tb/tb_tmr_pair_top.sv
module tb_tmr_pair_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] gate_pin = '0;
  logic [1:0] ovf_clr = '0;
  logic [1:0] ovf_flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  tmr_pair_top dut (
    .clk(clk), .rst(rst), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_FL = 2'd3;
  // entry: {op, addr, data/ticks, expected, requirement}
  localparam int NV = 56;
  localparam logic [24:0] VEC [NV] = '{
    {OP_RD, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 low byte 0
    {OP_RD, 3'd4, 8'h00, 8'h00, 4'd1},   // R1 mode
    {OP_RD, 3'd5, 8'h00, 8'h00, 4'd1},   // R1 control
    {OP_FL, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 flags
    {OP_WR, 3'd4, 8'h01, 8'h00, 4'd2},   // R2 ch0 mode 01
    {OP_WR, 3'd0, 8'hFE, 8'h00, 4'd2},
    {OP_WR, 3'd1, 8'hFF, 8'h00, 4'd2},
    {OP_RD, 3'd0, 8'h00, 8'hFE, 4'd2},   // R2 readback
    {OP_RD, 3'd4, 8'h00, 8'h01, 4'd2},   // R2 mode readback
    {OP_TK, 3'd0, 8'd3,  8'h00, 4'd3},   // R3 run off
    {OP_RD, 3'd0, 8'h00, 8'hFE, 4'd3},
    {OP_WR, 3'd5, 8'h01, 8'h00, 4'd6},   // run0
    {OP_TK, 3'd0, 8'd1,  8'h00, 4'd6},
    {OP_RD, 3'd0, 8'h00, 8'hFF, 4'd6},   // R6
    {OP_FL, 3'd0, 8'h00, 8'h00, 4'd6},
    {OP_TK, 3'd0, 8'd1,  8'h00, 4'd6},
    {OP_RD, 3'd0, 8'h00, 8'h00, 4'd6},
    {OP_RD, 3'd1, 8'h00, 8'h00, 4'd6},
    {OP_FL, 3'd0, 8'h00, 8'h01, 4'd6},   // R6 flag set
    {OP_RD, 3'd5, 8'h00, 8'h11, 4'd2},   // R2 control layout
    {OP_WR, 3'd5, 8'h01, 8'h00, 4'd2},   // sw clears flag
    {OP_FL, 3'd0, 8'h00, 8'h00, 4'd2},
    {OP_WR, 3'd4, 8'h02, 8'h00, 4'd8},   // R8 mode 10
    {OP_WR, 3'd1, 8'h80, 8'h00, 4'd8},
    {OP_WR, 3'd0, 8'hFE, 8'h00, 4'd8},
    {OP_TK, 3'd0, 8'd2,  8'h00, 4'd8},
    {OP_RD, 3'd0, 8'h00, 8'h80, 4'd8},   // R8 reloaded
    {OP_FL, 3'd0, 8'h00, 8'h01, 4'd8},
    {OP_TK, 3'd0, 8'd1,  8'h00, 4'd8},
    {OP_RD, 3'd0, 8'h00, 8'h81, 4'd8},
    {OP_RD, 3'd1, 8'h00, 8'h80, 4'd8},   // R8 high byte kept
    {OP_WR, 3'd5, 8'h01, 8'h00, 4'd7},
    {OP_WR, 3'd4, 8'h00, 8'h00, 4'd7},   // R7 mode 00
    {OP_WR, 3'd0, 8'hFD, 8'h00, 4'd7},
    {OP_WR, 3'd1, 8'hFF, 8'h00, 4'd7},
    {OP_TK, 3'd0, 8'd2,  8'h00, 4'd7},
    {OP_RD, 3'd1, 8'h00, 8'hFF, 4'd7},   // R7 high held
    {OP_RD, 3'd0, 8'h00, 8'hFF, 4'd7},
    {OP_FL, 3'd0, 8'h00, 8'h00, 4'd7},
    {OP_TK, 3'd0, 8'd1,  8'h00, 4'd7},
    {OP_RD, 3'd0, 8'h00, 8'hE0, 4'd7},   // R7 bits 7:5 kept
    {OP_RD, 3'd1, 8'h00, 8'h00, 4'd7},
    {OP_FL, 3'd0, 8'h00, 8'h01, 4'd7},
    {OP_WR, 3'd5, 8'h03, 8'h00, 4'd9},   // R9 both run
    {OP_WR, 3'd4, 8'h33, 8'h00, 4'd9},
    {OP_WR, 3'd0, 8'hFF, 8'h00, 4'd9},
    {OP_WR, 3'd1, 8'hFE, 8'h00, 4'd9},
    {OP_WR, 3'd2, 8'h12, 8'h00, 4'd9},
    {OP_WR, 3'd3, 8'h34, 8'h00, 4'd9},
    {OP_TK, 3'd0, 8'd2,  8'h00, 4'd9},
    {OP_RD, 3'd0, 8'h00, 8'h01, 4'd9},
    {OP_RD, 3'd1, 8'h00, 8'h00, 4'd9},
    {OP_FL, 3'd0, 8'h00, 8'h03, 4'd9},   // R9 flag1 from ch0 high
    {OP_RD, 3'd2, 8'h00, 8'h12, 4'd9},   // R9 ch1 frozen
    {OP_RD, 3'd3, 8'h00, 8'h34, 4'd9},
    {OP_RD, 3'd7, 8'h00, 8'h00, 4'd2}    // R2 unused address
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input int req);
    @(negedge clk); reg_addr = a;
    @(negedge clk); check(reg_rdata, exp, req);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reg_rdata, 8'h00, 1);            // R1 rdata in reset
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][24:23])
        OP_WR: wr(VEC[v][22:20], VEC[v][19:12]);
        OP_RD: rd(VEC[v][22:20], VEC[v][11:4], int'(VEC[v][3:0]));
        OP_TK: ticks(int'(VEC[v][19:12]));
        default: begin
          @(negedge clk);
          check({6'd0, ovf_flag}, VEC[v][11:4], int'(VEC[v][3:0]));
        end
      endcase
    end

    // R9: high half of ch0 stops when run 1 is cleared
    wr(3'd5, 8'h01);
    ticks(1);
    rd(3'd1, 8'h00, 9);
    rd(3'd0, 8'h02, 9);

    // R4: gating
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd5, 8'h01);
    gate_pin[0] = 1'b0;
    ticks(3);
    rd(3'd0, 8'h00, 4);
    gate_pin[0] = 1'b1;
    ticks(2);
    rd(3'd0, 8'h02, 4);

    // R5: falling edges sampled at ticks
    wr(3'd4, 8'h05);
    wr(3'd0, 8'h00);
    cnt_pin[0] = 1'b1; ticks(1);
    cnt_pin[0] = 1'b0; ticks(1);
    rd(3'd0, 8'h01, 5);
    ticks(1);
    cnt_pin[0] = 1'b1; ticks(1);
    cnt_pin[0] = 1'b0; ticks(1);
    rd(3'd0, 8'h02, 5);
    @(negedge clk); cnt_pin[0] = 1'b1;
    @(negedge clk); cnt_pin[0] = 1'b0;
    @(negedge clk); cnt_pin[0] = 1'b1;
    ticks(1);
    rd(3'd0, 8'h02, 5);                    // R5 glitch between ticks unseen

    // R10: set wins over acknowledge, then acknowledge clears
    wr(3'd4, 8'h01);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    wr(3'd5, 8'h01);
    @(negedge clk); tick = 1'b1; ovf_clr = 2'b01;
    @(negedge clk); tick = 1'b0;
    check({6'd0, ovf_flag}, 8'h01, 10);
    @(negedge clk); ovf_clr = 2'b00;
    check({6'd0, ovf_flag}, 8'h00, 10);

    // R11: write beats count in the same cycle
    wr(3'd0, 8'h10);
    @(negedge clk); tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h40;
    @(negedge clk); tick = 1'b0; reg_we = 1'b0;
    rd(3'd0, 8'h40, 11);

    // R6 on channel 1
    wr(3'd4, 8'h10);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd5, 8'h02);
    ticks(1);
    rd(3'd3, 8'h00, 6);
    @(negedge clk);
    check({6'd0, ovf_flag}, 8'h02, 6);

    summary();
  end
endmodule